// File: doc/BRIEF.md
# Mode-Configurable Host-to-Core Receive FIFO

This block carries data written by a host bus interface into a processor core. The host side presents a write strobe with a 32-bit data word. The core side pulls 24-bit words with a read strobe and sees two flags: not-empty and not-full. The block has one storage array. Its shape depends on four mode inputs: a universal-bus enable, a master/target select, a format-code-nonzero bit that matters in master operation, and a transfer-format-nonzero bit that matters in target operation.

In the narrow configurations the array is a 24-bit FIFO six or five entries deep. Each core read returns one stored word. In the wide configuration it is a 32-bit FIFO three entries deep. Each entry is then delivered as two 16-bit reads, right-aligned and zero-extended, with the low half first. When the decoded configuration changes, the FIFO is flushed and the half-word toggle is cleared.

Top module: `rxf_host_core`

## Requirements
- R1: After a synchronous reset, not_empty is 0, not_full is 1 and rd_data is 0.
- R2: The configuration decodes as follows, with universal-bus taking priority. ubus_en=1 selects narrow, depth 5. ubus_en=0 with master_en=1 and fcode_nz=1 selects narrow, depth 6. ubus_en=0 with master_en=0 and tfmt_nz=1 selects narrow, depth 6. Every other combination selects wide, depth 3.
- R3: In a narrow configuration, each accepted read returns wr_data[23:0] of the oldest entry, in write order. Host bits 31:24 are discarded.
- R4: In the wide configuration, the first read of an entry returns {8'h00, word[15:0]} and the second returns {8'h00, word[31:16]}. The entry leaves the FIFO only after the second read.
- R5: not_empty is 1 exactly when at least one entry is held. not_full is 1 exactly when fewer entries are held than the depth of the selected configuration.
- R6: A write while full and a read while empty are ignored. Stored contents and flags are unchanged, and rd_data holds its value.
- R7: A read and a write in the same cycle are judged against the occupancy before that cycle. Both take effect when the FIFO is neither full nor empty. When it is full, the write is ignored. When it is empty, the read is ignored.
- R8: When the decoded configuration differs from that of the previous cycle, the FIFO empties at that clock edge, the half-word toggle returns to the low half, and any strobe in that cycle is ignored. A change of mode inputs that leaves the decoded configuration the same does not flush.
- R9: rd_data changes only on the clock edge that accepts a read, and it holds its value at all other times.
- R10: The pointers wrap at the depth of the selected configuration, so write order is preserved over long mixed traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ubus_en | input | 1 | Universal-bus mode select |
| master_en | input | 1 | 1 = bus-master operation, 0 = target operation |
| fcode_nz | input | 1 | Master format code is nonzero |
| tfmt_nz | input | 1 | Target transfer-format field is nonzero |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write data |
| rd_en | input | 1 | Core read strobe |
| rd_data | output | 24 | Registered core read data |
| not_empty | output | 1 | At least one entry is held |
| not_full | output | 1 | Room for one more entry in the selected configuration |

## Verification
Three kinds of event can fall in the same cycle: a host write and a core read, and either of these together with a configuration change. The bench forces both strobes together at full, at empty, in the middle of the FIFO, and on the cycle a mode input changes. In wide mode it does this on both the low-half and the high-half read. A bench model applies the rules of R7 and R8 to the occupancy before each edge and predicts the flags and rd_data. The outputs are compared at the falling edge after each cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    CFG_N6 = 2'd0,
    CFG_N5 = 2'd1,
    CFG_W3 = 2'd2
  } rxf_cfg_e;
endpackage

// File: rtl/rxf_mode_ctl.sv
module rxf_mode_ctl
  import rxf_pkg::*;
#(
  parameter int DEPTH_N6 = 6,
  parameter int DEPTH_N5 = 5,
  parameter int DEPTH_W3 = 3,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ubus_en,
  input  logic          master_en,
  input  logic          fcode_nz,
  input  logic          tfmt_nz,
  output logic          flush,
  output logic          wide_q,
  output logic [CW-1:0] depth_q
);
  rxf_cfg_e cfg_d, cfg_q;

  // universal-bus wins; then master/target each pick by their own field
  always_comb begin
    if (ubus_en)        cfg_d = CFG_N5;
    else if (master_en) cfg_d = fcode_nz ? CFG_N6 : CFG_W3;
    else                cfg_d = tfmt_nz  ? CFG_N6 : CFG_W3;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_d;
    else     cfg_q <= cfg_d;
  end

  assign flush  = (cfg_d != cfg_q);
  assign wide_q = (cfg_q == CFG_W3);

  always_comb begin
    case (cfg_q)
      CFG_N5:  depth_q = CW'(DEPTH_N5);
      CFG_W3:  depth_q = CW'(DEPTH_W3);
      default: depth_q = CW'(DEPTH_N6);
    endcase
  end

  // R2: a universal-bus cycle always settles on the five-deep shape
  a_r2_ubus_depth: assert property (@(posedge clk) disable iff (rst)
    ubus_en |=> (depth_q == CW'(DEPTH_N5) && !wide_q));
endmodule

// File: rtl/rxf_ptrs.sv
module rxf_ptrs #(
  parameter int PW = 3,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wide,
  input  logic [CW-1:0] depth,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          half,
  output logic          wr_go,
  output logic          rd_go
);
  logic          pop;
  logic [CW-1:0] last;

  assign last  = depth - CW'(1);
  assign wr_go = wr_req && !flush && (count < depth);
  assign rd_go = rd_req && !flush && (count != '0);
  assign pop   = rd_go && (!wide || half);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p,
                                         input logic [CW-1:0] lim);
    if (CW'(p) == lim) return '0;
    return p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      half   <= 1'b0;
    end else begin
      if (wr_go) wr_ptr <= step(wr_ptr, last);
      if (pop)   rd_ptr <= step(rd_ptr, last);
      case ({wr_go, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (rd_go && wide) half <= ~half;
    end
  end

  // R5: occupancy never exceeds the active depth
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= depth);
  // R8: a configuration change empties the FIFO and rewinds the toggle
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0 && !half));
  // R6: a write into a full FIFO moves nothing
  a_r6_full_write: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !rd_req && !flush && count == depth)
      |=> ($stable(wr_ptr) && $stable(count)));
  // R6: a read from an empty FIFO moves nothing
  a_r6_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_req && !flush && count == '0)
      |=> ($stable(rd_ptr) && count == '0));
  // R4: the half toggle is idle outside the wide shape
  a_r4_half_narrow: assert property (@(posedge clk) disable iff (rst)
    !wide |-> !half);
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int HOST_W    = 32,
  parameter int CORE_W    = 24,
  parameter int DEPTH_MAX = 6,
  parameter int PW        = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic [PW-1:0]     wr_ptr,
  input  logic [HOST_W-1:0] wr_data,
  input  logic              rd_go,
  input  logic [PW-1:0]     rd_ptr,
  input  logic              wide,
  input  logic              half,
  output logic [CORE_W-1:0] rd_data
);
  localparam int HALF_W = HOST_W / 2;

  logic [HOST_W-1:0] mem [DEPTH_MAX];
  logic [HOST_W-1:0] word;
  logic [CORE_W-1:0] lane;
  logic [HALF_W-1:0] hsel;

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_ptr] <= wr_data;
  end

  assign word = mem[rd_ptr];
  assign hsel = half ? word[HOST_W-1:HALF_W] : word[HALF_W-1:0];

  generate
    if (CORE_W > HALF_W) begin : g_zext
      always_comb lane = wide ? {{(CORE_W-HALF_W){1'b0}}, hsel} : word[CORE_W-1:0];
    end else begin : g_trunc
      always_comb lane = wide ? hsel[CORE_W-1:0] : word[CORE_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_go) rd_data <= lane;
  end

  // R4: wide reads leave the upper byte zero
  a_r4_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (rd_go && wide) |=> (rd_data[CORE_W-1:HALF_W] == '0));
  // R9: output register holds unless a read was accepted
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> $stable(rd_data));
endmodule

// File: rtl/rxf_host_core.sv
module rxf_host_core #(
  parameter int HOST_W   = 32,
  parameter int CORE_W   = 24,
  parameter int DEPTH_N6 = 6,
  parameter int DEPTH_N5 = 5,
  parameter int DEPTH_W3 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ubus_en,
  input  logic              master_en,
  input  logic              fcode_nz,
  input  logic              tfmt_nz,
  input  logic              wr_en,
  input  logic [HOST_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [CORE_W-1:0] rd_data,
  output logic              not_empty,
  output logic              not_full
);
  localparam int DEPTH_MAX = (DEPTH_N6 > DEPTH_N5)
                           ? ((DEPTH_N6 > DEPTH_W3) ? DEPTH_N6 : DEPTH_W3)
                           : ((DEPTH_N5 > DEPTH_W3) ? DEPTH_N5 : DEPTH_W3);
  localparam int PW = (DEPTH_MAX > 1) ? $clog2(DEPTH_MAX) : 1;
  localparam int CW = $clog2(DEPTH_MAX + 1);

  logic          flush, wide;
  logic [CW-1:0] depth, count;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          half, wr_go, rd_go;

  rxf_mode_ctl #(
    .DEPTH_N6(DEPTH_N6), .DEPTH_N5(DEPTH_N5), .DEPTH_W3(DEPTH_W3), .CW(CW)
  ) u_mode (
    .clk(clk), .rst(rst), .ubus_en(ubus_en), .master_en(master_en),
    .fcode_nz(fcode_nz), .tfmt_nz(tfmt_nz),
    .flush(flush), .wide_q(wide), .depth_q(depth)
  );

  rxf_ptrs #(.PW(PW), .CW(CW)) u_ptrs (
    .clk(clk), .rst(rst), .flush(flush), .wide(wide), .depth(depth),
    .wr_req(wr_en), .rd_req(rd_en),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count), .half(half),
    .wr_go(wr_go), .rd_go(rd_go)
  );

  rxf_store #(
    .HOST_W(HOST_W), .CORE_W(CORE_W), .DEPTH_MAX(DEPTH_MAX), .PW(PW)
  ) u_store (
    .clk(clk), .rst(rst), .wr_go(wr_go), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .rd_go(rd_go), .rd_ptr(rd_ptr), .wide(wide), .half(half),
    .rd_data(rd_data)
  );

  assign not_empty = (count != '0);
  assign not_full  = (count < depth);

  // R7: with room and data both, a paired read/write keeps occupancy
  a_r7_pair_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !flush && not_empty && not_full && !wide)
      |=> $stable(count));
  // R6: a read on empty leaves the data output untouched
  a_r6_empty_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !not_empty) |=> $stable(rd_data));
endmodule

// File: tb/sim_rxf_host_core.sv
`timescale 1ns/1ps
module sim_rxf_host_core;
  logic        clk = 1'b0;
  logic        rst;
  logic        ubus_en, master_en, fcode_nz, tfmt_nz;
  logic        wr_en, rd_en;
  logic [31:0] wr_data;
  logic [23:0] rd_data;
  logic        not_empty, not_full;

  always #4 clk = ~clk;

  rxf_host_core u0 (
    .clk(clk), .rst(rst), .ubus_en(ubus_en), .master_en(master_en),
    .fcode_nz(fcode_nz), .tfmt_nz(tfmt_nz), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .not_empty(not_empty), .not_full(not_full)
  );

  int          tests = 0;
  int          fails = 0;
  logic [31:0] q[$];
  int          prev_cfg;
  bit          half_m;
  logic [23:0] exp_rd;

  // 0 = narrow six, 1 = narrow five, 2 = wide three
  function automatic int cfg_of(bit u, bit m, bit f, bit t);
    if (u) return 1;
    if (m) return f ? 0 : 2;
    return t ? 0 : 2;
  endfunction

  function automatic int depth_of(int c);
    return (c == 0) ? 6 : (c == 1) ? 5 : 3;
  endfunction

  task automatic check(string tag);
    bit ene, enf;
    ene = (q.size() != 0);
    enf = (q.size() < depth_of(prev_cfg));
    tests++;
    if (rd_data !== exp_rd || not_empty !== ene || not_full !== enf) begin
      fails++;
      $display("FAIL %s: rd_data=%h ne=%b nf=%b expected rd_data=%h ne=%b nf=%b",
               tag, rd_data, not_empty, not_full, exp_rd, ene, enf);
    end
  endtask

  task automatic set_mode(bit u, bit m, bit f, bit t);
    ubus_en = u; master_en = m; fcode_nz = f; tfmt_nz = t;
  endtask

  task automatic cyc(bit w, bit r, logic [31:0] d, string tag);
    int  c;
    bit  full, empty;
    logic [31:0] e;
    wr_en = w; rd_en = r; wr_data = d;
    c = cfg_of(ubus_en, master_en, fcode_nz, tfmt_nz);
    if (c != prev_cfg) begin
      q.delete();
      half_m = 1'b0;
      prev_cfg = c;
    end else begin
      full  = (q.size() == depth_of(c));
      empty = (q.size() == 0);
      if (r && !empty) begin
        e = q[0];
        if (c == 2) begin
          exp_rd = half_m ? {8'h00, e[31:16]} : {8'h00, e[15:0]};
          if (half_m) void'(q.pop_front());
          half_m = ~half_m;
        end else begin
          exp_rd = e[23:0];
          void'(q.pop_front());
        end
      end
      if (w && !full) q.push_back(d);
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    set_mode(0, 1, 1, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    prev_cfg = cfg_of(ubus_en, master_en, fcode_nz, tfmt_nz);
    half_m = 1'b0; exp_rd = '0;
    check("R1");

    // R2/R3/R6: master, nonzero format code, depth six; upper byte dropped
    for (int i = 0; i < 7; i++) cyc(1, 0, 32'hA5000000 | (i * 32'h00010203), "R2");
    cyc(1, 0, 32'hDEADBEEF, "R6");
    for (int i = 0; i < 6; i++) cyc(0, 1, '0, "R3");
    cyc(0, 1, '0, "R6");
    cyc(0, 1, '0, "R9");

    // R8/R4: master, zero format code -> wide three
    set_mode(0, 1, 0, 0);
    cyc(1, 1, 32'h11112222, "R8");
    for (int i = 0; i < 4; i++) cyc(1, 0, 32'hC0DE0000 + i * 32'h00050003, "R2");
    for (int i = 0; i < 7; i++) cyc(0, 1, '0, "R4");

    // R8: target with zero field decodes to the same wide shape -> no flush
    cyc(1, 0, 32'h89ABCDEF, "R4");
    cyc(0, 1, '0, "R4");
    set_mode(0, 0, 1, 0);
    cyc(0, 1, '0, "R8");
    cyc(1, 0, 32'h13572468, "R8");
    cyc(0, 1, '0, "R8");
    set_mode(1, 0, 1, 0);
    cyc(0, 0, '0, "R8");
    set_mode(0, 0, 1, 0);
    cyc(0, 0, '0, "R8");
    cyc(1, 0, 32'hFEDC4321, "R8");
    cyc(0, 1, '0, "R8");

    // R2: target nonzero field -> six; universal-bus overrides master
    set_mode(0, 0, 0, 1);
    for (int i = 0; i < 7; i++) cyc(1, 0, 32'h00400000 + i, "R2");
    set_mode(1, 1, 1, 1);
    for (int i = 0; i < 6; i++) cyc(1, 0, 32'h00500000 + i, "R2");
    cyc(1, 1, 32'h00BADBAD, "R7");
    cyc(1, 1, 32'h00600001, "R7");
    for (int i = 0; i < 6; i++) cyc(0, 1, '0, "R3");
    cyc(1, 1, 32'h00777777, "R7");

    // R7: paired strobes at full / mid / empty in wide shape
    set_mode(0, 1, 0, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 32'hAAAA0000 + i, "R7");
    cyc(1, 1, 32'h0BAD0BAD, "R7");
    cyc(1, 1, 32'h0BAD0BAE, "R7");
    cyc(1, 1, 32'h12345678, "R7");
    cyc(1, 1, 32'h9ABCDEF0, "R7");
    for (int i = 0; i < 8; i++) cyc(0, 1, '0, "R7");
    cyc(1, 1, 32'h55556666, "R7");
    cyc(1, 1, 32'h77778888, "R7");

    // R10: random traffic with occasional configuration changes
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 99) == 0)
        set_mode($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
      cyc($urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0, $urandom, "R10");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule